// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block sits between a bus master and a synchronous SRAM that holds cache lines. The master presents a start address and a one-cycle burst request. The sequencer latches that address once. It then produces every beat address of a line-sized burst from its own beat counter, so the master never drives another address during the burst.

The ordering is chosen per burst by a mode input. In wrap-around order the burst begins at the requested word, counts upward modulo the line and returns to the line start. In linear order the first beat is forced to the line start and the words follow in ascending order. The SRAM address, chip enable and write enable all come straight from registers. The first beat therefore occupies two clocks, a setup cycle followed by the data cycle, and every later beat occupies one clock.

A beat-valid strobe marks each data cycle. A busy flag covers the whole burst, and a one-cycle done pulse coincides with the final beat. Requests that arrive while the sequencer is busy are dropped.

Top module: `sram_burst_seq`

## Requirements
- R1: The start address is sampled only in the cycle a request is accepted; the upper line bits (addr above bit 1) of `sram_addr` stay at that sampled value for the whole burst, whatever `addr_in` does afterwards.
- R2: The first beat takes two clocks. In the cycle after acceptance, `sram_ce` is 1, `beat_valid` is 0 and `sram_addr` already holds the first beat address. In the next cycle `beat_valid` is 1 and the address is unchanged.
- R3: Each later beat takes exactly one clock. `beat_valid` stays high for BEATS (default 4) consecutive cycles, with a new address in each.
- R4: When `mode_wrap`=1 at acceptance, the word bits addr[1:0] of the beats are s, s+1, s+2, s+3 modulo 4, where s = addr_in[1:0].
- R5: When `mode_wrap`=0 at acceptance, the word bits are forced to 0 on the first beat and then run 0, 1, 2, 3.
- R6: `wr` is sampled at acceptance, and `sram_we` equals it through every burst cycle that has `sram_ce` high.
- R7: A request is accepted only while `busy` is 0. A request that is asserted while `busy` is 1 changes neither the addresses nor the length of the current burst, and it does not start another burst.
- R8: `busy` is 1 from the cycle after acceptance through the final beat and is 0 in the cycle after the final beat. `done` is a one-cycle pulse that coincides with the final beat.
- R9: A synchronous reset, including one in the middle of a burst, leaves `busy`, `done`, `beat_valid`, `sram_ce` and `sram_we` at 0 and `sram_addr` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Burst request, sampled while idle |
| wr | input | 1 | 1 = write burst, 0 = read burst |
| mode_wrap | input | 1 | 1 = wrap-around order, 0 = linear fill |
| addr_in | input | AW | Start word address |
| sram_addr | output | AW | Registered SRAM word address |
| sram_ce | output | 1 | Registered SRAM chip enable |
| sram_we | output | 1 | Registered SRAM write enable |
| beat_valid | output | 1 | Data cycle of a beat |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Final beat of the burst |

## Verification
A beat counter that slips shows up within one beat. Either a word bit of `sram_addr` repeats or skips, or `done` lands one cycle away from the fourth `beat_valid`. A corrupted start word or line register is visible on the first address, one cycle after acceptance. A sequencer that leaves or re-enters the idle state when it should not is caught by `busy` and `sram_ce` in the cycle after the final beat, or by an extra or missing valid beat when a request arrives in the middle of a burst.

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int AW    = 16,
  parameter int BEATS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr,
  input  logic          mode_wrap,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce,
  output logic          sram_we,
  output logic          beat_valid,
  output logic          busy,
  output logic          done
);
  localparam int WB = $clog2(BEATS);
  localparam logic [WB-1:0] LAST = WB'(BEATS - 1);

  typedef enum logic [1:0] {IDLE, LEAD, RUN} st_t;
  st_t st;

  logic [AW-WB-1:0] line_q;
  logic [WB-1:0]    start_q, cnt_q;
  logic [WB-1:0]    cnt_nx, word_nx, start_in;

  assign start_in = mode_wrap ? addr_in[WB-1:0] : '0;
  assign cnt_nx   = cnt_q + 1'b1;
  assign word_nx  = start_q + cnt_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= IDLE;
      line_q     <= '0;
      start_q    <= '0;
      cnt_q      <= '0;
      sram_addr  <= '0;
      sram_ce    <= 1'b0;
      sram_we    <= 1'b0;
      beat_valid <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      case (st)
        IDLE: begin
          beat_valid <= 1'b0;
          done       <= 1'b0;
          if (req) begin
            line_q    <= addr_in[AW-1:WB];
            start_q   <= start_in;
            cnt_q     <= '0;
            sram_addr <= {addr_in[AW-1:WB], start_in};
            sram_ce   <= 1'b1;
            sram_we   <= wr;
            busy      <= 1'b1;
            st        <= LEAD;
          end else begin
            sram_ce <= 1'b0;
            sram_we <= 1'b0;
            busy    <= 1'b0;
          end
        end
        LEAD: begin
          beat_valid <= 1'b1;
          done       <= (cnt_q == LAST);
          st         <= RUN;
        end
        RUN: begin
          if (cnt_q == LAST) begin
            beat_valid <= 1'b0;
            done       <= 1'b0;
            sram_ce    <= 1'b0;
            sram_we    <= 1'b0;
            busy       <= 1'b0;
            st         <= IDLE;
          end else begin
            cnt_q      <= cnt_nx;
            sram_addr  <= {line_q, word_nx};
            beat_valid <= 1'b1;
            done       <= (cnt_nx == LAST);
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_burst_seq_chk.sv
module sram_burst_seq_chk #(
  parameter int AW    = 16,
  parameter int BEATS = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          wr,
  input logic          mode_wrap,
  input logic [AW-1:0] sram_addr,
  input logic          sram_ce,
  input logic          sram_we,
  input logic          beat_valid,
  input logic          busy,
  input logic          done
);
  localparam int WB = $clog2(BEATS);

  a_r2_lead_cycle: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> sram_ce && !beat_valid);

  a_r2_lead_to_data: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> beat_valid && $stable(sram_addr));

  a_r3_word_step: assert property (@(posedge clk) disable iff (rst)
    beat_valid && $past(beat_valid) |->
      sram_addr[WB-1:0] == WB'($past(sram_addr[WB-1:0]) + 1'b1));

  a_r1_line_held: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(sram_addr[AW-1:WB]));

  a_r5_linear_aligned: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) && !$past(mode_wrap) |-> sram_addr[WB-1:0] == '0);

  a_r6_we_sampled: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> sram_we == $past(wr));

  a_r6_we_held: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(sram_we));

  a_r8_done_on_beat: assert property (@(posedge clk) disable iff (rst)
    done |-> beat_valid && busy);

  a_r8_done_ends: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy && !done);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sram_ce && !sram_we && !beat_valid && !done);
endmodule

bind sram_burst_seq sram_burst_seq_chk #(.AW(AW), .BEATS(BEATS)) chk_i (.*);

// File: tb/sram_burst_seq_tb_top.sv
module sram_burst_seq_tb_top;
  localparam int AW = 16;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0, wr = 1'b0, mode_wrap = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] sram_addr;
  logic sram_ce, sram_we, beat_valid, busy, done;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  sram_burst_seq #(.AW(AW), .BEATS(4)) dut_i (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .mode_wrap(mode_wrap),
    .addr_in(addr_in), .sram_addr(sram_addr), .sram_ce(sram_ce),
    .sram_we(sram_we), .beat_valid(beat_valid), .busy(busy), .done(done));

  // {mode_wrap, wr, addr, w0, w1, w2, w3}
  localparam logic [25:0] VEC [6] = '{
    {1'b1, 1'b0, 16'h1232, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b0, 1'b1, 16'h1232, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b1, 1'b1, 16'hABC3, 2'd3, 2'd0, 2'd1, 2'd2},
    {1'b1, 1'b0, 16'h0000, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b0, 1'b0, 16'hFFFF, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b1, 1'b1, 16'h7FF1, 2'd1, 2'd2, 2'd3, 2'd0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // one burst; noise=1 keeps req high with a different address during the burst (R7)
  task automatic burst(input logic m, input logic w, input logic [15:0] a,
                       input logic [7:0] words, input logic noise);
    logic [15:0] ea;
    @(negedge clk);
    req = 1'b1; wr = w; mode_wrap = m; addr_in = a;
    @(negedge clk);
    if (noise) begin addr_in = ~a; wr = ~w; mode_wrap = ~m; end
    else req = 1'b0;
    ea = {a[15:2], words[7:6]};
    chk(busy && sram_ce && !beat_valid && !done && sram_addr == ea && sram_we == w,
        "R2 lead cycle", {busy, sram_ce, beat_valid, done, sram_we, 11'd0, sram_addr},
        {5'b11000 | {4'd0, w}, 11'd0, ea});
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      ea = {a[15:2], words[7-2*b -: 2]};
      chk(beat_valid && busy && sram_ce && sram_addr == ea && sram_we == w,
          m ? "R4 R1 R3 R6 wrap beat" : "R5 R1 R3 R6 linear beat",
          {beat_valid, busy, sram_we, 13'd0, sram_addr}, {2'b11, w, 13'd0, ea});
      chk(done == (b == 3), "R8 done timing", {31'd0, done}, {31'd0, b == 3});
      if (b == 3 && noise) req = 1'b0;
    end
    @(negedge clk);
    chk(!busy && !sram_ce && !sram_we && !beat_valid && !done,
        noise ? "R7 R8 idle after burst" : "R8 idle after burst",
        {busy, sram_ce, sram_we, beat_valid, done}, 32'd0);
    if (noise) begin
      @(negedge clk);
      chk(!busy && !sram_ce, "R7 no extra burst", {busy, sram_ce}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !sram_ce && !sram_we && !beat_valid && !done && sram_addr == '0,
        "R9 reset state", {busy, sram_ce, sram_we, beat_valid, done, 11'd0, sram_addr}, 32'd0);
    rst = 1'b0;
    foreach (VEC[i])
      burst(VEC[i][25], VEC[i][24], VEC[i][23:8], VEC[i][7:0], 1'b0);
    // R7: requests held during a burst are dropped
    burst(1'b1, 1'b0, 16'h4562, {2'd2, 2'd3, 2'd0, 2'd1}, 1'b1);
    // R9: reset in the middle of a burst
    @(negedge clk);
    req = 1'b1; mode_wrap = 1'b1; addr_in = 16'h0101; wr = 1'b1;
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!busy && !sram_ce && !sram_we && !beat_valid && !done && sram_addr == '0,
        "R9 mid-burst reset", {busy, sram_ce, sram_we, beat_valid, done, 11'd0, sram_addr}, 32'd0);
    // after reset a fresh burst runs normally
    burst(1'b0, 1'b1, 16'h0102, {2'd0, 2'd1, 2'd2, 2'd3}, 1'b0);
    summary();
  end
endmodule